// File: doc/BRIEF.md
# Class-D Power Stage Fault Protection Controller

This block is the digital protection and status logic for a power stage built from four half-bridges (index 0 to 3). Every clock it samples a junction temperature code, two supply undervoltage flags, and per-half-bridge overcurrent and bootstrap-undervoltage flags. From these it decides which half-bridges must be placed in high impedance. It also drives three active-low status lines: a shutdown indicator and two temperature warnings.

Faults fall into two kinds. Overtemperature errors and sustained overcurrent (overload) latch until the block is reset. Supply and bootstrap undervoltage clear as soon as the flag drops. The output mode decides how far a local overload spreads. In the bridged and single-ended modes it removes the pair of half-bridges it belongs to. In the parallel-bridged mode it removes all four. A bootstrap fault only ever removes its own half-bridge.

All outputs are registered. A warning or latched fault reaches the pins two or three clock edges after the input that causes it.

Top module: `amp_fault_guard`

## Requirements
- R1: The first warning line `otw1N` goes low once `tempCode` is greater than WARN1_C (default 100). It returns high only when `tempCode` is at or below WARN1_C minus HYST_C (default 75). Between those two values it holds its state.
- R2: The second warning line `otw2N` goes low once `tempCode` is greater than WARN2_C (default 125). It returns high only when `tempCode` is at or below WARN2_C minus HYST_C (default 100). It is never low while `otw1N` is high.
- R3: A `tempCode` at or above ERR_C (default 155) latches an overtemperature error. The error drives `sdN` low and sets all four `hizEn` bits. It stays latched after the temperature falls, until reset. Throughout, the warning lines keep following R1 and R2.
- R4: An `ocFlag[i]` held high for OL_CYCLES consecutive clocks latches an overload fault on half-bridge i. The fault drives `sdN` low and stays latched until reset. A burst one clock shorter has no effect on any output.
- R5: With `modeSel` = 2'b01 (parallel bridged), an overload on any half-bridge sets all four `hizEn` bits. With any other `modeSel` value (00 bridged, 10 or 11 single-ended), an overload on half-bridge 0 or 1 sets `hizEn[1:0]`, and one on half-bridge 2 or 3 sets `hizEn[3:2]`.
- R6: While `gateUv` or `logicUv` is high, `sdN` is low and all four `hizEn` bits are set. Both return to normal without a reset once the flag drops.
- R7: `bootUv[i]` high sets only `hizEn[i]` and leaves `sdN` high, in every mode. The bit clears without a reset once the flag drops.
- R8: While `rstN` is low, `sdN`, `otw1N` and `otw2N` are high and `hizEn` is 4'b1111, even with faults present. Latched faults are cleared by the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Device reset, active low, asynchronous assert |
| tempCode | input | TEMP_W | Junction temperature, unsigned whole degrees Celsius |
| gateUv | input | 1 | Gate-drive supply below threshold |
| logicUv | input | 1 | Logic supply below threshold |
| ocFlag | input | 4 | Per-half-bridge overcurrent flag |
| bootUv | input | 4 | Per-half-bridge bootstrap undervoltage flag |
| modeSel | input | 2 | 00 bridged, 01 parallel bridged, 10/11 single-ended |
| hizEn | output | 4 | Per-half-bridge high-impedance enable, 1 = off |
| sdN | output | 1 | Shutdown indicator, active low |
| otw1N | output | 1 | First temperature warning, active low |
| otw2N | output | 1 | Second temperature warning, active low |

## Verification
The bench ramps the temperature up and down through every code below the error level. If a design released a warning at its set threshold instead of after the hysteresis drop, or used greater-or-equal for the set test, it would show a wrong warning level at one or more codes on the way down or at the thresholds. For each mode and each half-bridge, overcurrent bursts of OL_CYCLES minus one and of exactly OL_CYCLES clocks separate an off-by-one timer (early or missed trip) from a correct one. The same sweep catches wrong grouping, which would leave a neighbour switching or shut the whole stage in a pair mode. Further checks confirm that the overtemperature error holds after cooling, that reset overrides it, and that bootstrap and supply faults recover without a reset. A design that latched these, or spread a bootstrap fault to its pair, would fail them.

// File: rtl/amp_fault_pkg.sv
package amp_fault_pkg;

  localparam int NUM_HB = 4;

  typedef enum logic [1:0] {
    MODE_BRIDGED  = 2'b00,
    MODE_PARALLEL = 2'b01,
    MODE_SINGLE   = 2'b10,
    MODE_SINGLE_B = 2'b11
  } outMode_e;

  // Registered condition strobes handed from the datapath to the control.
  typedef struct packed {
    logic              warn1;
    logic              warn2;
    logic              overTemp;
    logic              supplyLow;
    logic [NUM_HB-1:0] bootLow;
    logic [NUM_HB-1:0] overload;
  } faultStrobes_t;

endpackage

// File: rtl/amp_fault_datapath.sv
module amp_fault_datapath
  import amp_fault_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int WARN1_C    = 100,
  parameter int WARN2_C    = 125,
  parameter int HYST_C     = 25,
  parameter int ERR_C      = 155,
  parameter int OL_CYCLES  = 260000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic              gateUv,
  input  logic              logicUv,
  input  logic [NUM_HB-1:0] ocFlag,
  input  logic [NUM_HB-1:0] bootUv,
  output faultStrobes_t     strobes
);

  localparam int OLW = $clog2(OL_CYCLES + 1);
  localparam logic [OLW-1:0]    OL_TERM  = OL_CYCLES[OLW-1:0];
  localparam logic [TEMP_W-1:0] W1_SET   = WARN1_C[TEMP_W-1:0];
  localparam logic [TEMP_W-1:0] W1_CLR   = (WARN1_C - HYST_C);
  localparam logic [TEMP_W-1:0] W2_SET   = WARN2_C[TEMP_W-1:0];
  localparam logic [TEMP_W-1:0] W2_CLR   = (WARN2_C - HYST_C);
  localparam logic [TEMP_W-1:0] ERR_TRIP = ERR_C[TEMP_W-1:0];

  logic warn1Q, warn2Q, overTempQ, supplyLowQ;
  logic [NUM_HB-1:0] bootLowQ;
  logic [NUM_HB-1:0] overloadHit;

  // Warning comparators with hysteresis: set above threshold, clear at or
  // below the lower bound, hold in between.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warn1Q <= 1'b0;
      warn2Q <= 1'b0;
    end else begin
      if (tempCode > W1_SET)       warn1Q <= 1'b1;
      else if (tempCode <= W1_CLR) warn1Q <= 1'b0;
      if (tempCode > W2_SET)       warn2Q <= 1'b1;
      else if (tempCode <= W2_CLR) warn2Q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overTempQ  <= 1'b0;
      supplyLowQ <= 1'b0;
      bootLowQ   <= '0;
    end else begin
      overTempQ  <= (tempCode >= ERR_TRIP);
      supplyLowQ <= gateUv | logicUv;
      bootLowQ   <= bootUv;
    end
  end

  // One overload timer per half-bridge; any gap in the flag restarts it.
  for (genvar g = 0; g < NUM_HB; g++) begin : g_olTimer
    logic [OLW-1:0] olCount;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  olCount <= '0;
      else if (!ocFlag[g])        olCount <= '0;
      else if (olCount != OL_TERM) olCount <= olCount + 1'b1;
    end
    assign overloadHit[g] = (olCount == OL_TERM);

    // Overload timer only reports after a clock on which the flag was high.
    assert_overload_needs_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
      overloadHit[g] |-> $past(ocFlag[g]));
  end

  assign strobes.warn1     = warn1Q;
  assign strobes.warn2     = warn2Q;
  assign strobes.overTemp  = overTempQ;
  assign strobes.supplyLow = supplyLowQ;
  assign strobes.bootLow   = bootLowQ;
  assign strobes.overload  = overloadHit;

  assert_warn1_rise_above_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warn1Q) |-> ($past(tempCode) > W1_SET));

  assert_warn2_within_warn1_R2: assert property (@(posedge clk) disable iff (!rstN)
    warn2Q |-> warn1Q);

endmodule

// File: rtl/amp_fault_control.sv
module amp_fault_control
  import amp_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  faultStrobes_t     strobes,
  output logic [NUM_HB-1:0] hizEn,
  output logic              sdN,
  output logic              otw1N,
  output logic              otw2N
);

  logic              otLatch;
  logic [NUM_HB-1:0] olLatch;
  logic [NUM_HB-1:0] spreadHiz;
  logic [NUM_HB-1:0] hizNext;
  logic              sdNext;
  logic              parallelMode;

  assign parallelMode = (outMode_e'(modeSel) == MODE_PARALLEL);

  // Latched faults: cleared only by reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otLatch <= 1'b0;
      olLatch <= '0;
    end else begin
      if (strobes.overTemp) otLatch <= 1'b1;
      olLatch <= olLatch | strobes.overload;
    end
  end

  // Mode-dependent spreading of a latched overload.
  for (genvar g = 0; g < NUM_HB; g++) begin : g_spread
    localparam int PAIR_LO = (g / 2) * 2;
    always_comb begin
      if (parallelMode) spreadHiz[g] = |olLatch;
      else              spreadHiz[g] = olLatch[PAIR_LO] | olLatch[PAIR_LO + 1];
    end
  end

  always_comb begin
    hizNext = spreadHiz | strobes.bootLow;
    if (strobes.supplyLow || otLatch) hizNext = '1;
    sdNext = !(strobes.supplyLow || otLatch || (|olLatch));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hizEn <= '1;
      sdN   <= 1'b1;
      otw1N <= 1'b1;
      otw2N <= 1'b1;
    end else begin
      hizEn <= hizNext;
      sdN   <= sdNext;
      otw1N <= !strobes.warn1;
      otw2N <= !strobes.warn2;
    end
  end

  assert_ot_error_shuts_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    otLatch |=> (!sdN && (hizEn == '1)));

  assert_shutdown_covers_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    !sdN |-> ($countones(hizEn) >= 2));

  assert_ot_latch_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    otLatch |=> otLatch);

endmodule

// File: rtl/amp_fault_guard.sv
module amp_fault_guard
  import amp_fault_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int WARN1_C   = 100,
  parameter int WARN2_C   = 125,
  parameter int HYST_C    = 25,
  parameter int ERR_C     = 155,
  parameter int OL_CYCLES = 260000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic              gateUv,
  input  logic              logicUv,
  input  logic [3:0]        ocFlag,
  input  logic [3:0]        bootUv,
  input  logic [1:0]        modeSel,
  output logic [3:0]        hizEn,
  output logic              sdN,
  output logic              otw1N,
  output logic              otw2N
);

  faultStrobes_t strobes;

  amp_fault_datapath #(
    .TEMP_W(TEMP_W), .WARN1_C(WARN1_C), .WARN2_C(WARN2_C),
    .HYST_C(HYST_C), .ERR_C(ERR_C), .OL_CYCLES(OL_CYCLES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .tempCode(tempCode),
    .gateUv(gateUv), .logicUv(logicUv),
    .ocFlag(ocFlag), .bootUv(bootUv), .strobes(strobes)
  );

  amp_fault_control i_control (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .strobes(strobes),
    .hizEn(hizEn), .sdN(sdN), .otw1N(otw1N), .otw2N(otw2N)
  );

endmodule

// File: tb/test_amp_fault_guard.sv
module test_amp_fault_guard;

  localparam int OL = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] tempCode = 8'd20;
  logic       gateUv = 1'b0, logicUv = 1'b0;
  logic [3:0] ocFlag = '0, bootUv = '0;
  logic [1:0] modeSel = 2'b00;
  logic [3:0] hizEn;
  logic       sdN, otw1N, otw2N;

  int errors = 0;
  int checks = 0;
  bit w1Model = 0, w2Model = 0;

  always #10 clk = ~clk;

  amp_fault_guard #(.OL_CYCLES(OL)) i_amp_fault_guard (
    .clk(clk), .rstN(rstN), .tempCode(tempCode), .gateUv(gateUv),
    .logicUv(logicUv), .ocFlag(ocFlag), .bootUv(bootUv), .modeSel(modeSel),
    .hizEn(hizEn), .sdN(sdN), .otw1N(otw1N), .otw2N(otw2N)
  );

  // Compare {hizEn, sdN, otw1N, otw2N} against the expected pattern.
  task automatic expect_pins(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {hizEn, sdN, otw1N, otw2N};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hiz/sd/otw1/otw2 actual=%b expected=%b (temp=%0d mode=%b)",
               tag, act, exp, tempCode, modeSel);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
  endtask

  task automatic temp_step(input int t);
    tempCode = t[7:0];
    if (t > 100) w1Model = 1; else if (t <= 75) w1Model = 0;
    if (t > 125) w2Model = 1; else if (t <= 100) w2Model = 0;
    settle();
    expect_pins(w2Model ? "R2 warn2 hysteresis" : "R1 warn1 hysteresis",
                {4'b0000, 1'b1, ~w1Model, ~w2Model});
  endtask

  function automatic logic [3:0] group_of(input int hb, input logic [1:0] m);
    if (m == 2'b01) return 4'b1111;
    return (hb < 2) ? 4'b0011 : 4'b1100;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    // R8: state while reset is held.
    repeat (2) @(negedge clk);
    expect_pins("R8 reset state", 7'b1111_1_11);
    rstN = 1'b1;
    settle();
    expect_pins("R8 after release", 7'b0000_1_11);

    // R1/R2: full up and down ramp below the error level.
    for (int t = 0; t <= 154; t++) temp_step(t);
    for (int t = 154; t >= 0; t--) temp_step(t);
    tempCode = 8'd20;
    settle();

    // R3: overtemperature error latches; warnings keep tracking temperature.
    tempCode = 8'd155;
    settle();
    expect_pins("R3 error trip", 7'b1111_0_00);
    tempCode = 8'd20;
    settle();
    expect_pins("R3 error held after cooling", 7'b1111_0_11);
    tempCode = 8'd154;
    settle();
    expect_pins("R3 below trip no release", 7'b1111_0_00);
    // R8: reset overrides an active error condition.
    tempCode = 8'd160;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    expect_pins("R8 reset over fault", 7'b1111_1_11);
    tempCode = 8'd20;
    @(negedge clk);
    rstN = 1'b1;
    settle();
    expect_pins("R8 latch cleared", 7'b0000_1_11);

    // R4/R5: overload timing and grouping in every mode and half-bridge.
    for (int m = 0; m < 4; m++) begin
      for (int hb = 0; hb < 4; hb++) begin
        modeSel = m[1:0];
        do_reset();
        ocFlag[hb] = 1'b1;
        repeat (OL - 1) @(negedge clk);
        ocFlag[hb] = 1'b0;
        settle();
        expect_pins("R4 short burst ignored", 7'b0000_1_11);
        ocFlag[hb] = 1'b1;
        repeat (OL) @(negedge clk);
        ocFlag[hb] = 1'b0;
        settle();
        expect_pins("R5 overload grouping", {group_of(hb, m[1:0]), 3'b0_11});
        repeat (20) @(negedge clk);
        expect_pins("R4 overload stays latched", {group_of(hb, m[1:0]), 3'b0_11});
      end
    end

    // R7: bootstrap fault is local and self-clearing in every mode.
    for (int m = 0; m < 4; m++) begin
      for (int hb = 0; hb < 4; hb++) begin
        modeSel = m[1:0];
        do_reset();
        bootUv[hb] = 1'b1;
        settle();
        expect_pins("R7 bootstrap local", {4'(1 << hb), 3'b1_11});
        bootUv[hb] = 1'b0;
        settle();
        expect_pins("R7 bootstrap recovers", 7'b0000_1_11);
      end
    end

    // R6: supply undervoltage shuts all and recovers by itself.
    modeSel = 2'b00;
    do_reset();
    gateUv = 1'b1;
    settle();
    expect_pins("R6 gate supply low", 7'b1111_0_11);
    gateUv = 1'b0;
    settle();
    expect_pins("R6 gate supply recovers", 7'b0000_1_11);
    logicUv = 1'b1;
    tempCode = 8'd130;
    settle();
    expect_pins("R6 logic supply low with warnings", 7'b1111_0_00);
    logicUv = 1'b0;
    settle();
    expect_pins("R6 logic supply recovers", 7'b0000_1_00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule